// File: doc/BRIEF.md
# Per-CPU Interrupt Level Merger

Each processor in a multi-CPU system gets one copy of this block. It keeps a 32-bit pending word that holds fifteen software-raised interrupts, a sampled copy of the local timer line and a sticky level-15 request. It combines these with the already-masked hard-level vector that the system router produces for this CPU, and it drives a 15-bit interrupt-level vector plus a registered 4-bit code that names the highest active level.

Software reaches the pending word through a small word-addressed port. Word 0 reads the status. Word 1 clears the bits that are set in the written data. Word 2 sets bits in the same way. Software can only raise the soft bits. It can clear the soft bits and the level-15 bit. The timer bit follows its input line and cannot be written. Status reads also show the hard levels that the router marks as pending for this CPU, including sources that are disabled there. Those bits are never stored.

Top module: `cpu_level_merger`

## Requirements
- R1: After reset the pending word, the status read of word 0, the level vector (with zero hard inputs) and the encoded level are all zero.
- R2: A write to word 2 ORs the written data into pending bits 31..17 only. Written bits 16..0 have no effect.
- R3: A write to word 1 clears the pending bits that are set in the data, limited to bits 31..17 and bit 15. Bit 14 and the other low bits are not affected.
- R4: A read of word 0 (combinational, on `rdData`) returns the pending word ORed with `hardStatus`. Status bit k of `hardStatus` (level k+1) appears at word bit k+1. Words 1 to 3 read as zero.
- R5: Pending bit 17+k drives `levelsOut[k]`, which is interrupt level k+1. So bit 17 drives level 1 and bit 31 drives level 15.
- R6: Pending bit 14 is level sensitive. It takes the value of `timerIn` at every clock edge and drives level 14 (`levelsOut[13]`). No mask applies to it.
- R7: While `lvl15In` is high, pending bit 15 is set at each clock edge. The bit stays set after the input falls, until a word-1 write clears it. It drives level 15 (`levelsOut[14]`) without any mask.
- R8: `levelsOut` is the OR of `hardLevels`, the two unmaskable bits and the soft levels. `levelsOut` is combinational from the pending word and `hardLevels`. `hardStatus` never affects `levelsOut`.
- R9: `encLevel` is the number of the highest set level (15 down to 1), or 0 when no level is set. It is registered, so it follows `levelsOut` one clock later.
- R10: Writes to word 0 and word 3 leave the pending word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| timerIn | input | 1 | Local timer line, level sensitive |
| lvl15In | input | 1 | Level-15 request, captured sticky |
| hardLevels | input | 15 | Masked hard levels from the router, bit k = level k+1 |
| hardStatus | input | 15 | Unmasked hard levels for status display, bit k = level k+1 |
| levelsOut | output | 15 | Interrupt level vector to the CPU, bit k = level k+1 |
| encLevel | output | 4 | Registered highest active level, 0 when none |

## Verification
The bench builds the block with its default two-bit word address. This puts all four words in reach, including the two that must ignore writes and read as zero. With the default fifteen levels, each of the soft, timer, level-15 and hard paths can be driven alone and together. It also lets the bench check the priority code at both ends of its range, 1 and 15, as well as in the middle.

// File: rtl/lvl_merge_pkg.sv
package lvl_merge_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_LEVELS  = 15;
  localparam int ENC_W       = $clog2(NUM_LEVELS + 1);
  localparam int SOFT_SHIFT  = 16;
  localparam int TIMER_BIT   = 14;
  localparam int L15_BIT     = 15;
  localparam logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000;
  localparam logic [DATA_W-1:0] CLR_MASK  = SOFT_MASK | (32'h1 << L15_BIT);

  typedef struct packed {
    logic              clrStb;
    logic              setStb;
    logic [DATA_W-1:0] data;
  } regCmdT;
endpackage

// File: rtl/lvl_merge_ctrl.sv
module lvl_merge_ctrl
  import lvl_merge_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output regCmdT            cmd,
  output logic              rdStatus
);
  localparam logic [ADDR_W-1:0] WORD_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] WORD_CLEAR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_SET    = ADDR_W'(2);

  always_comb begin
    cmd.clrStb = wrEn && (addr == WORD_CLEAR);
    cmd.setStb = wrEn && (addr == WORD_SET);
    cmd.data   = wrData;
    rdStatus   = (addr == WORD_STATUS);
  end
endmodule

// File: rtl/lvl_merge_datapath.sv
module lvl_merge_datapath
  import lvl_merge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  regCmdT                cmd,
  input  logic                  timerIn,
  input  logic                  lvl15In,
  input  logic [NUM_LEVELS-1:0] hardLevels,
  input  logic [NUM_LEVELS-1:0] hardStatus,
  output logic [DATA_W-1:0]     statusWord,
  output logic [NUM_LEVELS-1:0] levelsOut
);
  logic [DATA_W-1:0]     pending;
  logic [DATA_W-1:0]     pendingNxt;
  logic [NUM_LEVELS-1:0] softLevels;
  logic [DATA_W-1:0]     hardWord;

  always_comb begin
    pendingNxt = pending;
    if (cmd.clrStb) pendingNxt = pendingNxt & ~(cmd.data & CLR_MASK);
    if (cmd.setStb) pendingNxt = pendingNxt | (cmd.data & SOFT_MASK);
    pendingNxt[TIMER_BIT] = timerIn;
    if (lvl15In) pendingNxt[L15_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= pendingNxt;
  end

  // Soft bit SOFT_SHIFT+1+k feeds level k+1; hard status bit k shows at word bit k+1.
  genvar k;
  generate
    for (k = 0; k < NUM_LEVELS; k++) begin : gMap
      assign softLevels[k]  = pending[SOFT_SHIFT + 1 + k];
      assign hardWord[k + 1] = hardStatus[k];
    end
    for (k = NUM_LEVELS + 1; k < DATA_W; k++) begin : gZero
      assign hardWord[k] = 1'b0;
    end
  endgenerate
  assign hardWord[0] = 1'b0;

  always_comb begin
    levelsOut = hardLevels | softLevels;
    levelsOut[TIMER_BIT - 1] = levelsOut[TIMER_BIT - 1] | pending[TIMER_BIT];
    levelsOut[L15_BIT - 1]   = levelsOut[L15_BIT - 1] | pending[L15_BIT];
    statusWord = pending | hardWord;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setStb |=> ((pending & ($past(cmd.data) & SOFT_MASK)) == ($past(cmd.data) & SOFT_MASK))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clrStb && !cmd.setStb && !lvl15In) |=> ((pending & $past(cmd.data) & CLR_MASK) == '0)); // R3
  AST_TIMER_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (levelsOut[TIMER_BIT - 1] || !$past(timerIn)) && (pending[TIMER_BIT] == $past(timerIn))); // R6
  AST_L15_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pending[L15_BIT] && !cmd.clrStb) |=> pending[L15_BIT]); // R7
endmodule

// File: rtl/lvl_merge_encoder.sv
module lvl_merge_encoder
  import lvl_merge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] levelsIn,
  output logic [ENC_W-1:0]      encLevel
);
  logic [ENC_W-1:0] encNxt;

  always_comb begin
    encNxt = '0;
    for (int i = 1; i <= NUM_LEVELS; i++) begin
      if (levelsIn[i-1]) encNxt = ENC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) encLevel <= '0;
    else       encLevel <= encNxt;
  end

  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (levelsIn == '0) |=> (encLevel == '0)); // R9
  AST_ENC_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (levelsIn != '0) |=> (encLevel != '0)); // R9
  AST_ENC_TOP: assert property (@(posedge clk) disable iff (!rstN)
    levelsIn[NUM_LEVELS-1] |=> (encLevel == ENC_W'(NUM_LEVELS))); // R9
endmodule

// File: rtl/cpu_level_merger.sv
module cpu_level_merger
  import lvl_merge_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  timerIn,
  input  logic                  lvl15In,
  input  logic [NUM_LEVELS-1:0] hardLevels,
  input  logic [NUM_LEVELS-1:0] hardStatus,
  output logic [NUM_LEVELS-1:0] levelsOut,
  output logic [ENC_W-1:0]      encLevel
);
  regCmdT            cmd;
  logic              rdStatus;
  logic [DATA_W-1:0] statusWord;

  lvl_merge_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cmd(cmd), .rdStatus(rdStatus)
  );

  lvl_merge_datapath uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .timerIn(timerIn), .lvl15In(lvl15In),
    .hardLevels(hardLevels), .hardStatus(hardStatus),
    .statusWord(statusWord), .levelsOut(levelsOut)
  );

  lvl_merge_encoder uEnc (
    .clk(clk), .rstN(rstN), .levelsIn(levelsOut), .encLevel(encLevel)
  );

  assign rdData = rdStatus ? statusWord : '0;

  AST_HARD_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    ((levelsOut & hardLevels) == hardLevels)); // R8
  AST_IGNORED_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(0) || addr == ADDR_W'(3)) && !timerIn && !lvl15In
     && $stable(timerIn) && $stable(lvl15In)) |=> $stable(uData.pending)); // R10
endmodule

// File: tb/tb_cpu_level_merger.sv
module tb_cpu_level_merger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timerIn = 1'b0;
  logic        lvl15In = 1'b0;
  logic [14:0] hardLevels = '0;
  logic [14:0] hardStatus = '0;
  logic [14:0] levelsOut;
  logic [3:0]  encLevel;

  int nChecks = 0;
  int nFails  = 0;

  cpu_level_merger #(.ADDR_W(2)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .timerIn(timerIn), .lvl15In(lvl15In),
    .hardLevels(hardLevels), .hardStatus(hardStatus),
    .levelsOut(levelsOut), .encLevel(encLevel)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0; addr = 2'd0; wrData = '0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 status", rdData, 32'h0);
    chk("R1 levels", {17'h0, levelsOut}, 32'h0);
    chk("R1 enc", {28'h0, encLevel}, 32'h0);
  endtask

  task automatic t_soft_all();
    regWrite(2'd2, 32'hFFFF_FFFF);
    chk("R2 set masks low bits", rdData, 32'hFFFE_0000);
    chk("R5 all soft levels", {17'h0, levelsOut}, 32'h0000_7FFF);
    step();
    chk("R9 enc 15", {28'h0, encLevel}, 32'd15);
    regWrite(2'd1, 32'hFFFF_FFFF);
    chk("R3 clear all soft", rdData, 32'h0);
    step();
    chk("R9 enc idle", {28'h0, encLevel}, 32'd0);
  endtask

  task automatic t_soft_single();
    regWrite(2'd2, 32'h0002_0000);
    chk("R5 bit17 level1", {17'h0, levelsOut}, 32'h0000_0001);
    step();
    chk("R9 enc 1", {28'h0, encLevel}, 32'd1);
    regWrite(2'd2, 32'h0100_0000);
    chk("R5 bit24 level8", {17'h0, levelsOut}, 32'h0000_0081);
    chk("R9 enc lags one cycle", {28'h0, encLevel}, 32'd1);
    step();
    chk("R9 enc 8", {28'h0, encLevel}, 32'd8);
    regWrite(2'd1, 32'h0002_0000);
    chk("R3 partial clear", rdData, 32'h0100_0000);
    regWrite(2'd1, 32'h0100_0000);
    chk("R3 cleared", rdData, 32'h0);
  endtask

  task automatic t_timer();
    timerIn = 1'b1;
    step(); #1;
    chk("R6 timer bit14", rdData, 32'h0000_4000);
    chk("R6 timer level14", {17'h0, levelsOut}, 32'h0000_2000);
    regWrite(2'd1, 32'h0000_7FFF);
    chk("R3 bit14 not clearable", rdData, 32'h0000_4000);
    step();
    chk("R9 enc 14", {28'h0, encLevel}, 32'd14);
    timerIn = 1'b0;
    step(); #1;
    chk("R6 timer drops", rdData, 32'h0);
    chk("R6 level14 drops", {17'h0, levelsOut}, 32'h0);
  endtask

  task automatic t_lvl15();
    lvl15In = 1'b1;
    step();
    lvl15In = 1'b0;
    #1;
    chk("R7 bit15 set", rdData, 32'h0000_8000);
    chk("R7 level15", {17'h0, levelsOut}, 32'h0000_4000);
    step(); #1;
    chk("R7 sticky", rdData, 32'h0000_8000);
    chk("R9 enc 15 from l15", {28'h0, encLevel}, 32'd15);
    regWrite(2'd1, 32'h0000_8000);
    chk("R7 cleared by word1", rdData, 32'h0);
    regWrite(2'd2, 32'h0000_FFFF);
    chk("R2 cannot set low bits", rdData, 32'h0);
  endtask

  task automatic t_hard();
    hardLevels = 15'h0005;
    #1;
    chk("R8 hard only", {17'h0, levelsOut}, 32'h0000_0005);
    chk("R4 hard not in status", rdData, 32'h0);
    regWrite(2'd2, 32'h0010_0000);
    chk("R8 hard OR soft", {17'h0, levelsOut}, 32'h0000_000D);
    step();
    chk("R9 enc 4", {28'h0, encLevel}, 32'd4);
    hardStatus = 15'h0010;
    #1;
    chk("R8 status input ignored", {17'h0, levelsOut}, 32'h0000_000D);
    chk("R4 status reflects hard", rdData, 32'h0010_0020);
    addr = 2'd1; #1;
    chk("R4 word1 reads zero", rdData, 32'h0);
    addr = 2'd0;
    hardLevels = '0; hardStatus = '0;
    regWrite(2'd1, 32'hFFFF_FFFF);
    chk("R3 clean", rdData, 32'h0);
  endtask

  task automatic t_unused();
    regWrite(2'd0, 32'hFFFF_FFFF);
    chk("R10 word0 write ignored", rdData, 32'h0);
    regWrite(2'd3, 32'hFFFF_FFFF);
    chk("R10 word3 write ignored", rdData, 32'h0);
    chk("R10 levels unchanged", {17'h0, levelsOut}, 32'h0);
    addr = 2'd3; #1;
    chk("R4 word3 reads zero", rdData, 32'h0);
    addr = 2'd0;
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset();
        @(negedge clk);
        rstN = 1'b1;
        step(); #1;
        t_reset();
        t_soft_all();
        t_soft_single();
        t_timer();
        t_lvl15();
        t_hard();
        t_unused();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule